// File: doc/BRIEF.md
# Auto-ranging capacitance measurement sequencer

This block is the digital controller of a capacitance-to-time sensing front end. A measurement cycle has two conversions. The first conversion charges the sensing capacitor together with its parasitic load. The second charges the parasitic load alone. Before each conversion the block holds the capacitor in discharge for a fixed number of clocks. It then counts clocks until the comparator output shows its first rising edge. At the end of the cycle it subtracts the parasitic count from the combined count and reports the difference with a one-cycle valid strobe.

The charge-current range has five binary steps. They are coded 0 to 4, and the nominal span is 1.6 pF times 2^code, from 1.6 pF up to 25.6 pF. Each step sets a conversion window of BASE_WINDOW << code clocks. With the 1 ns default clock this is 3.2 µs at code 0 and 51.2 µs at code 4.

A conversion that reaches the end of its window is a timeout. On a timeout the block discards the cycle, moves one range up and starts again. If the range is already at the top, it flags overrange instead. When the parasitic conversion stays small for two cycles in a row, the block moves one range down.

The comparator input is assumed to be synchronous to the clock.

Top module: `cap_autorange_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, discharge is 1, pathSel is 0, rangeCode is 0, resultValid is 0 and overRange is 0.
- R2: Every conversion is preceded by exactly DISCH_CYCLES consecutive clocks with discharge high.
- R3: Each cycle converts with pathSel=0 (sensing plus parasitic) first, then with pathSel=1 (parasitic only). pathSel changes only in a clock where discharge is high.
- R4: A conversion's count is the number of clocks between the first clock with discharge low and the clock in which the comparator is first seen high after being low. If the comparator is seen high in the first such clock, the count is 0.
- R5: After a complete cycle, result equals countA minus countB and resultValid is high for exactly one clock.
- R6: When countB exceeds countA, result is 0.
- R7: The window at range code r is BASE_WINDOW << r clocks. A rising edge seen at count window-1 is still accepted. If no edge has been seen by then, the conversion times out.
- R8: On a timeout below the top code, no result is reported, rangeCode rises by one and the cycle restarts with pathSel=0. This also clears the low-load streak.
- R9: On a timeout at the top code (4), overRange is high for one clock and rangeCode stays 4.
- R10: A completed cycle whose countB is below a quarter of the window extends the low-load streak. A completed cycle without that condition clears the streak. When the streak reaches two, rangeCode drops by one (it never goes below 0) and the streak restarts.
- R11: rangeCode never exceeds 4 and changes by at most one step per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, one count per period |
| rstN | input | 1 | Active-low synchronous reset |
| cmpIn | input | 1 | Threshold comparator output |
| discharge | output | 1 | High holds the capacitor discharged |
| pathSel | output | 1 | 0 = sensing plus parasitic, 1 = parasitic only |
| rangeCode | output | 3 | Charge-current range step, 0 to 4 |
| result | output | 17 | Signed difference countA - countB, clamped at 0 |
| resultValid | output | 1 | One-clock strobe for result |
| overRange | output | 1 | One-clock flag on timeout at the top range |

## Verification
Some properties are checked on every clock:
- the discharge run never outlasts its length;
- pathSel moves only while the capacitor is discharged;
- the valid and overrange strobes each last a single clock;
- a reported result is never negative;
- overrange occurs only at the top code;
- the range code stays at or below 4 and moves one step at a time.

Other behaviour can only be shown by the bench's scenarios:
- the exact count captured for a given comparator delay and the arithmetic of the difference;
- acceptance of an edge in the last clock of the window;
- the climb through every range on repeated timeouts;
- the two-cycle streak before stepping down, including the case where a non-low cycle breaks the streak.

// File: rtl/cap_autorange_pkg.sv
package cap_autorange_pkg;

  typedef enum logic [2:0] {
    ST_DISCH_A = 3'd0,
    ST_CONV_A  = 3'd1,
    ST_DISCH_B = 3'd2,
    ST_CONV_B  = 3'd3,
    ST_DONE    = 3'd4
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic capA;
    logic capB;
  } dpCtrl_t;

endpackage

// File: rtl/cap_autorange_dp.sv
module cap_autorange_dp
  import cap_autorange_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BASE_WINDOW = 3200,
  parameter int RANGE_W     = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmpIn,
  input  dpCtrl_t                 ctrl,
  input  logic [RANGE_W-1:0]      rangeCode,
  output logic                    edgeSeen,
  output logic                    limitHit,
  output logic                    bLow,
  output logic signed [CNT_W:0]   result
);

  logic                  cmpPrev;
  logic [CNT_W-1:0]      count;
  logic [CNT_W-1:0]      cntA;
  logic [CNT_W-1:0]      cntB;
  logic [CNT_W:0]        winLim;
  logic signed [CNT_W:0] diff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpPrev <= 1'b0;
      count   <= '0;
      cntA    <= '0;
      cntB    <= '0;
    end else begin
      cmpPrev <= cmpIn;
      if (ctrl.clrCnt) begin
        count <= '0;
      end else if (ctrl.incCnt && !(&count)) begin
        count <= count + 1'b1;
      end
      if (ctrl.capA) cntA <= count;
      if (ctrl.capB) cntB <= count;
    end
  end

  // Window length for the current range step
  assign winLim   = (CNT_W+1)'(BASE_WINDOW) << rangeCode;
  assign edgeSeen = cmpIn && !cmpPrev;
  assign limitHit = ({1'b0, count} == (winLim - 1'b1)) || (&count);
  assign bLow     = {1'b0, cntB} < (winLim >> 2);

  assign diff   = $signed({1'b0, cntA}) - $signed({1'b0, cntB});
  assign result = diff[CNT_W] ? '0 : diff;

endmodule

// File: rtl/cap_autorange_ctrl.sv
module cap_autorange_ctrl
  import cap_autorange_pkg::*;
#(
  parameter int DISCH_CYCLES = 16,
  parameter int NUM_RANGES   = 5,
  parameter int RANGE_W      = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               edgeSeen,
  input  logic               limitHit,
  input  logic               bLow,
  output dpCtrl_t            ctrl,
  output logic               discharge,
  output logic               pathSel,
  output logic [RANGE_W-1:0] rangeCode,
  output logic               resultValid,
  output logic               overRange
);

  localparam int DW = $clog2(DISCH_CYCLES + 1);
  localparam logic [RANGE_W-1:0] TOP_CODE = RANGE_W'(NUM_RANGES - 1);

  seqState_t     state;
  logic [DW-1:0] dischCnt;
  logic          lowStreak;
  logic          inDisch;
  logic          inConv;

  assign inDisch = (state == ST_DISCH_A) || (state == ST_DISCH_B);
  assign inConv  = (state == ST_CONV_A)  || (state == ST_CONV_B);

  always_comb begin
    ctrl.clrCnt = inDisch;
    ctrl.incCnt = inConv;
    ctrl.capA   = (state == ST_CONV_A) && edgeSeen;
    ctrl.capB   = (state == ST_CONV_B) && edgeSeen;
  end

  assign discharge   = inDisch;
  assign pathSel     = (state == ST_DISCH_B) || (state == ST_CONV_B) || (state == ST_DONE);
  assign resultValid = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_DISCH_A;
      dischCnt  <= '0;
      rangeCode <= '0;
      lowStreak <= 1'b0;
      overRange <= 1'b0;
    end else begin
      overRange <= 1'b0;
      case (state)
        ST_DISCH_A, ST_DISCH_B: begin
          if (dischCnt == DW'(DISCH_CYCLES - 1)) begin
            dischCnt <= '0;
            state    <= (state == ST_DISCH_A) ? ST_CONV_A : ST_CONV_B;
          end else begin
            dischCnt <= dischCnt + 1'b1;
          end
        end
        ST_CONV_A, ST_CONV_B: begin
          if (edgeSeen) begin
            state <= (state == ST_CONV_A) ? ST_DISCH_B : ST_DONE;
          end else if (limitHit) begin
            // Timeout: discard the cycle and widen the range
            state     <= ST_DISCH_A;
            lowStreak <= 1'b0;
            if (rangeCode == TOP_CODE) begin
              overRange <= 1'b1;
            end else begin
              rangeCode <= rangeCode + 1'b1;
            end
          end
        end
        ST_DONE: begin
          state <= ST_DISCH_A;
          if (bLow) begin
            if (lowStreak) begin
              lowStreak <= 1'b0;
              if (rangeCode != '0) rangeCode <= rangeCode - 1'b1;
            end else begin
              lowStreak <= 1'b1;
            end
          end else begin
            lowStreak <= 1'b0;
          end
        end
        default: state <= ST_DISCH_A;
      endcase
    end
  end

endmodule

// File: rtl/cap_autorange_seq.sv
module cap_autorange_seq
  import cap_autorange_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int BASE_WINDOW  = 3200,
  parameter int DISCH_CYCLES = 16,
  parameter int NUM_RANGES   = 5,
  parameter int RANGE_W      = $clog2(NUM_RANGES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmpIn,
  output logic                  discharge,
  output logic                  pathSel,
  output logic [RANGE_W-1:0]    rangeCode,
  output logic signed [CNT_W:0] result,
  output logic                  resultValid,
  output logic                  overRange
);

  dpCtrl_t dpCtrl;
  logic    edgeSeen;
  logic    limitHit;
  logic    bLow;

  cap_autorange_ctrl #(
    .DISCH_CYCLES(DISCH_CYCLES),
    .NUM_RANGES  (NUM_RANGES),
    .RANGE_W     (RANGE_W)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .edgeSeen   (edgeSeen),
    .limitHit   (limitHit),
    .bLow       (bLow),
    .ctrl       (dpCtrl),
    .discharge  (discharge),
    .pathSel    (pathSel),
    .rangeCode  (rangeCode),
    .resultValid(resultValid),
    .overRange  (overRange)
  );

  cap_autorange_dp #(
    .CNT_W      (CNT_W),
    .BASE_WINDOW(BASE_WINDOW),
    .RANGE_W    (RANGE_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmpIn    (cmpIn),
    .ctrl     (dpCtrl),
    .rangeCode(rangeCode),
    .edgeSeen (edgeSeen),
    .limitHit (limitHit),
    .bLow     (bLow),
    .result   (result)
  );

endmodule

// File: rtl/cap_autorange_chk.sv
module cap_autorange_chk #(
  parameter int CNT_W        = 16,
  parameter int DISCH_CYCLES = 16,
  parameter int NUM_RANGES   = 5,
  parameter int RANGE_W      = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  discharge,
  input logic                  pathSel,
  input logic [RANGE_W-1:0]    rangeCode,
  input logic signed [CNT_W:0] result,
  input logic                  resultValid,
  input logic                  overRange
);

  int unsigned dischRun;

  always_ff @(posedge clk) begin
    if (!rstN) dischRun <= 0;
    else       dischRun <= discharge ? dischRun + 1 : 0;
  end

  // R2: a discharge run never exceeds its fixed length
  a_r2_disch_len: assert property (@(posedge clk) disable iff (!rstN)
    discharge |-> (dischRun < DISCH_CYCLES));

  // R3: path select moves only while discharged
  a_r3_path_in_disch: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pathSel) |-> discharge);

  // R5: valid is a single-clock strobe
  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R5: no valid while the capacitor is held discharged
  a_r5_valid_not_disch: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> !discharge);

  // R6: reported result is never negative
  a_r6_nonneg: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> !result[CNT_W]);

  // R9: overrange only at the top code, one clock long
  a_r9_ovr_top: assert property (@(posedge clk) disable iff (!rstN)
    overRange |-> (int'(rangeCode) == NUM_RANGES - 1));

  a_r9_ovr_pulse: assert property (@(posedge clk) disable iff (!rstN)
    overRange |=> !overRange);

  // R11: code bounded and moves one step at a time
  a_r11_code_max: assert property (@(posedge clk) disable iff (!rstN)
    int'(rangeCode) <= NUM_RANGES - 1);

  a_r11_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rangeCode) |->
      ((int'(rangeCode) == int'($past(rangeCode)) + 1) ||
       (int'(rangeCode) == int'($past(rangeCode)) - 1)));

endmodule

bind cap_autorange_seq cap_autorange_chk #(
  .CNT_W       (CNT_W),
  .DISCH_CYCLES(DISCH_CYCLES),
  .NUM_RANGES  (NUM_RANGES),
  .RANGE_W     (RANGE_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .discharge  (discharge),
  .pathSel    (pathSel),
  .rangeCode  (rangeCode),
  .result     (result),
  .resultValid(resultValid),
  .overRange  (overRange)
);

// File: tb/cap_autorange_seq_tb_top.sv
module cap_autorange_seq_tb_top;

  localparam int CW   = 16;
  localparam int BASE = 40;
  localparam int DC   = 16;
  localparam int NR   = 5;
  localparam int RW   = 3;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                cmpIn = 1'b0;
  logic                discharge;
  logic                pathSel;
  logic [RW-1:0]       rangeCode;
  logic signed [CW:0]  result;
  logic                resultValid;
  logic                overRange;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int modelRange = 0;
  int modelStreak = 0;

  cap_autorange_seq #(
    .CNT_W       (CW),
    .BASE_WINDOW (BASE),
    .DISCH_CYCLES(DC),
    .NUM_RANGES  (NR),
    .RANGE_W     (RW)
  ) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .cmpIn      (cmpIn),
    .discharge  (discharge),
    .pathSel    (pathSel),
    .rangeCode  (rangeCode),
    .result     (result),
    .resultValid(resultValid),
    .overRange  (overRange)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Runs one conversion; entered at the first discharge clock
  task automatic doConv(input bit pB, input int k, output bit to);
    int n;
    to = 1'b0;
    cmpIn = 1'b0;
    n = 0;
    while (discharge) begin
      chk(pathSel == pB, "R3 pathSel during discharge", int'(pathSel), int'(pB));
      n++;
      @(negedge clk);
    end
    chk(n == DC, "R2 discharge length", n, DC);
    chk(pathSel == pB, "R3 pathSel during conversion", int'(pathSel), int'(pB));
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (discharge) begin
        to = 1'b1;
        return;
      end
    end
    cmpIn = 1'b1;
    @(negedge clk);
  endtask

  task automatic onTimeout();
    if (modelRange < NR - 1) begin
      modelRange++;
      chk(overRange == 1'b0, "R8 no overrange below top", int'(overRange), 0);
    end else begin
      chk(overRange == 1'b1, "R9 overrange at top", int'(overRange), 1);
    end
    modelStreak = 0;
    chk(int'(rangeCode) == modelRange, "R8 range after timeout", int'(rangeCode), modelRange);
    chk(pathSel == 1'b0, "R8 restart with first path", int'(pathSel), 0);
    chk(resultValid == 1'b0, "R8 no result on timeout", int'(resultValid), 0);
  endtask

  task automatic runMeas(input int kA, input int kB);
    bit to;
    int win;
    int expRes;
    win = BASE << modelRange;
    doConv(1'b0, kA, to);
    chk(to == (kA >= win), "R7 window on first conversion", int'(to), int'(kA >= win));
    if (to) begin
      onTimeout();
      return;
    end
    doConv(1'b1, kB, to);
    chk(to == (kB >= win), "R7 window on second conversion", int'(to), int'(kB >= win));
    if (to) begin
      onTimeout();
      return;
    end
    expRes = kA - kB;
    if (expRes < 0) expRes = 0;
    chk(resultValid == 1'b1, "R5 valid strobe", int'(resultValid), 1);
    if (kA < kB) chk(int'(result) == expRes, "R6 clamp to zero", int'(result), expRes);
    else         chk(int'(result) == expRes, "R4 R5 count difference", int'(result), expRes);
    chk(overRange == 1'b0, "R9 no overrange on good cycle", int'(overRange), 0);
    if (kB < win / 4) begin
      if (modelStreak == 1) begin
        if (modelRange > 0) modelRange--;
        modelStreak = 0;
      end else begin
        modelStreak = 1;
      end
    end else begin
      modelStreak = 0;
    end
    @(negedge clk);
    chk(resultValid == 1'b0, "R5 valid lasts one clock", int'(resultValid), 0);
    chk(int'(rangeCode) == modelRange, "R10 range after cycle", int'(rangeCode), modelRange);
    chk(discharge == 1'b1, "R3 next cycle starts discharged", int'(discharge), 1);
    chk(int'(rangeCode) <= NR - 1, "R11 code bound", int'(rangeCode), NR - 1);
  endtask

  initial begin
    wait (cyc > 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(discharge == 1'b1, "R1 reset discharge", int'(discharge), 1);
    chk(pathSel == 1'b0, "R1 reset pathSel", int'(pathSel), 0);
    chk(rangeCode == '0, "R1 reset range", int'(rangeCode), 0);
    chk(resultValid == 1'b0, "R1 reset valid", int'(resultValid), 0);
    chk(overRange == 1'b0, "R1 reset overrange", int'(overRange), 0);
    rstN = 1'b1;

    runMeas(30, 10);    // R5 plain difference
    runMeas(5, 9);      // R6 clamp, low streak 1
    runMeas(39, 12);    // R7 last window clock, R10 streak cleared
    runMeas(20, 3);     // R10 streak 1
    runMeas(20, 3);     // R10 streak 2 at code 0 stays 0
    runMeas(40, 0);     // R8 timeout -> code 1
    runMeas(79, 50);    // R7 edge at window-1 at code 1
    runMeas(10, 80);    // R8 timeout on second path -> code 2
    runMeas(200, 0);    // R8 -> code 3
    runMeas(400, 0);    // R8 -> code 4
    runMeas(700, 0);    // R9 overrange, stays 4
    runMeas(639, 100);  // R10 low streak 1 at code 4
    runMeas(300, 20);   // R10 step down -> 3
    runMeas(250, 300);  // R6 clamp, streak cleared
    runMeas(100, 10);
    runMeas(100, 10);   // R10 step down -> 2
    // near-exhaustive sweep over a small grid
    foreach (cap_a[i]) begin
      foreach (cap_b[j]) begin
        runMeas(cap_a[i], cap_b[j]);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int cap_a[5] = '{0, 1, 13, 41, 170};
  int cap_b[5] = '{0, 2, 25, 41, 9};

endmodule